// File: doc/BRIEF.md
# Carrier-Tracking BPSK Demodulator

This block recovers binary data from a sampled, carrier-modulated BPSK stream by locking a local oscillator to the incoming carrier. A phase accumulator drives a sine table that yields two references a quarter turn apart. Each incoming sample is multiplied by both references. Each product is smoothed by its own one-pole recursive low-pass section, which gives an in-phase arm and a quadrature arm.

The two smoothed arms are multiplied together. The product is scaled down and smoothed again to give a loop error. That error, scaled once more, is added to a nominal phase step. The sum is clamped between a lower and an upper bound, and the result becomes the oscillator's step for the next sample. A positive error speeds the oscillator up and a negative error slows it down. The data bit is taken from the sign of the in-phase arm. A lock flag reports whether the error has stayed small for a run of consecutive samples.

All state advances only on cycles where the input strobe is high. The nominal step, the step bounds and the lock threshold are run-time inputs, so software or a neighbouring block can set the carrier frequency and the pull range.

Top module: `costas_track`

## Requirements
- R1: The oscillator is a 16-bit phase accumulator. On each valid sample it adds the step that was in effect before that sample. Bits 15..10 form a table index k. The in-phase reference is S(k) and the quadrature reference is S((k+16) mod 64), where S(k) = round(127·sin(2πk/64)) as a signed 8-bit value.
- R2: On each valid sample, each arm value y (16-bit signed) becomes y + ((x·ref − y) >>> 4), where x is the signed 8-bit sample and >>> is an arithmetic shift. The in-phase arm value is driven on `iArm`.
- R3: On each valid sample, the loop error e (16-bit signed, on `loopErr`) becomes e + ((((I·Q) >>> 14) − e) >>> 4). I and Q are the arm values held before that sample.
- R4: On each valid sample, the step (on `phaseStep`) becomes nominal + (e >>> 2), using the error held before the sample. A positive error therefore raises the step and a negative error lowers it.
- R5: `bitOut` is 1 when `iArm` is zero or positive, and 0 when it is negative.
- R6: The step is first limited to at most `maxStep` and then raised to at least `minStep`, so `minStep` wins when the bounds cross.
- R7: When `inValid` is low, no output and no internal state changes, whatever `sampleIn` carries.
- R8: `locked` rises on the 64th consecutive valid sample at which |e| (the error held before that sample) is below `lockThresh`.
- R9: `locked` falls on the first valid sample at which |e| is not below `lockThresh`, and the run count restarts.
- R10: While `rst` is high, the phase, both arms and the error are zero, `locked` is low and the step is loaded from `nomStep`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Sample strobe; all state advances when high |
| sampleIn | input | 8 | Signed input sample |
| nomStep | input | 16 | Nominal phase step per sample |
| minStep | input | 16 | Lower bound of the phase step |
| maxStep | input | 16 | Upper bound of the phase step |
| lockThresh | input | 16 | Error magnitude below which a sample counts toward lock |
| iArm | output | 16 | Filtered in-phase arm (signed) |
| bitOut | output | 1 | Recovered data bit |
| loopErr | output | 16 | Filtered loop error (signed) |
| phaseStep | output | 16 | Oscillator step currently in effect |
| locked | output | 1 | Lock indication |

## Verification
The bench builds the block with its default parameters: a 16-bit accumulator, a filter shift of 4, an error scale of 14, a gain shift of 2 and a lock run of 64. With these values, every arm, error and step update is reproduced exactly in integer arithmetic, and the lock edge falls inside a short run of zero samples. The two step bounds and the lock threshold are inputs, so crossed bounds, clamping at either limit and a forced loss of lock can each be set up within a few samples. A modulated carrier run that is slightly off the nominal frequency, with data flips, then exercises the loop steering in both directions.

// File: rtl/costas_track_pkg.sv
package costas_track_pkg;

  localparam int LUT_AW  = 6;
  localparam int SINE_W  = 8;
  localparam int QUARTER = 16;

  typedef struct packed {
    logic advance;
  } ctlStrobes_t;

  // one quarter of the wave, entries 0..16 = round(127*sin(pi*r/32))
  function automatic logic signed [SINE_W-1:0] quarterSine(input logic [4:0] r);
    case (r)
      5'd0:  return 8'sd0;
      5'd1:  return 8'sd12;
      5'd2:  return 8'sd25;
      5'd3:  return 8'sd37;
      5'd4:  return 8'sd49;
      5'd5:  return 8'sd60;
      5'd6:  return 8'sd71;
      5'd7:  return 8'sd81;
      5'd8:  return 8'sd90;
      5'd9:  return 8'sd98;
      5'd10: return 8'sd106;
      5'd11: return 8'sd112;
      5'd12: return 8'sd117;
      5'd13: return 8'sd122;
      5'd14: return 8'sd125;
      5'd15: return 8'sd126;
      default: return 8'sd127;
    endcase
  endfunction

  function automatic logic signed [SINE_W-1:0] sineAt(input logic [LUT_AW-1:0] k);
    logic [4:0] half;
    logic [4:0] fold;
    logic signed [SINE_W-1:0] mag;
    half = k[4:0];
    fold = (half > 5'd16) ? 5'(6'd32 - {1'b0, half}) : half;
    if (k[4:0] == 5'd16) fold = 5'd16;
    mag = quarterSine(fold);
    return k[5] ? -mag : mag;
  endfunction

endpackage

// File: rtl/costas_track_arm.sv
module costas_track_arm #(
  parameter int SAMP_W     = 8,
  parameter int REF_W      = 8,
  parameter int FILT_SHIFT = 4,
  localparam int ARM_W     = SAMP_W + REF_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     advance,
  input  logic signed [SAMP_W-1:0] sampleIn,
  input  logic signed [REF_W-1:0]  refVal,
  output logic signed [ARM_W-1:0]  armVal
);

  logic signed [ARM_W-1:0] sampX;
  logic signed [ARM_W-1:0] refX;
  logic signed [ARM_W-1:0] mixed;
  logic signed [ARM_W:0]   diff;
  logic signed [ARM_W:0]   diffShift;

  assign sampX     = ARM_W'(sampleIn);
  assign refX      = ARM_W'(refVal);
  assign mixed     = sampX * refX;
  assign diff      = $signed({mixed[ARM_W-1], mixed}) - $signed({armVal[ARM_W-1], armVal});
  assign diffShift = diff >>> FILT_SHIFT;

  always_ff @(posedge clk) begin
    if (rst)          armVal <= '0;
    else if (advance) armVal <= armVal + diffShift[ARM_W-1:0];
  end

endmodule

// File: rtl/costas_track_dp.sv
module costas_track_dp
  import costas_track_pkg::*;
#(
  parameter int PHASE_W    = 16,
  parameter int SAMP_W     = 8,
  parameter int FILT_SHIFT = 4,
  parameter int ERR_SHIFT  = 14,
  parameter int GAIN_SHIFT = 2,
  localparam int ARM_W     = SAMP_W + SINE_W,
  localparam int PROD_W    = 2 * ARM_W,
  localparam int SUM_W     = PHASE_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ctlStrobes_t              ctrl,
  input  logic signed [SAMP_W-1:0] sampleIn,
  input  logic [PHASE_W-1:0]       nomStep,
  input  logic [PHASE_W-1:0]       minStep,
  input  logic [PHASE_W-1:0]       maxStep,
  output logic signed [ARM_W-1:0]  iArm,
  output logic signed [ARM_W-1:0]  loopErr,
  output logic [PHASE_W-1:0]       phaseStep
);

  logic [PHASE_W-1:0]       phaseAcc;
  logic [LUT_AW-1:0]        tblIdx [2];
  logic signed [SINE_W-1:0] refs   [2];
  logic signed [ARM_W-1:0]  arms   [2];

  assign tblIdx[0] = phaseAcc[PHASE_W-1 -: LUT_AW];
  assign tblIdx[1] = phaseAcc[PHASE_W-1 -: LUT_AW] + LUT_AW'(QUARTER);

  for (genvar g = 0; g < 2; g++) begin : g_arm
    assign refs[g] = sineAt(tblIdx[g]);
    costas_track_arm #(
      .SAMP_W(SAMP_W), .REF_W(SINE_W), .FILT_SHIFT(FILT_SHIFT)
    ) u_arm (
      .clk(clk), .rst(rst), .advance(ctrl.advance),
      .sampleIn(sampleIn), .refVal(refs[g]), .armVal(arms[g])
    );
  end

  assign iArm = arms[0];

  // error path: arm product, scale, one-pole smoothing
  logic signed [PROD_W-1:0] armProd;
  logic signed [PROD_W-1:0] armScaled;
  logic signed [ARM_W-1:0]  errTarget;
  logic signed [ARM_W:0]    errDiff;
  logic signed [ARM_W:0]    errDiffShift;

  assign armProd      = PROD_W'(arms[0]) * PROD_W'(arms[1]);
  assign armScaled    = armProd >>> ERR_SHIFT;
  assign errTarget    = armScaled[ARM_W-1:0];
  assign errDiff      = $signed({errTarget[ARM_W-1], errTarget}) - $signed({loopErr[ARM_W-1], loopErr});
  assign errDiffShift = errDiff >>> FILT_SHIFT;

  // step steering with clamp, lower bound applied last
  logic signed [ARM_W-1:0] errGain;
  logic signed [SUM_W-1:0] stepSum;
  logic signed [SUM_W-1:0] stepHiCut;
  logic signed [SUM_W-1:0] stepClamped;
  logic signed [SUM_W-1:0] minS;
  logic signed [SUM_W-1:0] maxS;

  assign errGain   = loopErr >>> GAIN_SHIFT;
  assign minS      = $signed({2'b00, minStep});
  assign maxS      = $signed({2'b00, maxStep});
  assign stepSum   = $signed({2'b00, nomStep}) + SUM_W'(errGain);
  assign stepHiCut = (stepSum > maxS) ? maxS : stepSum;
  assign stepClamped = (stepHiCut < minS) ? minS : stepHiCut;

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseAcc  <= '0;
      loopErr   <= '0;
      phaseStep <= nomStep;
    end else if (ctrl.advance) begin
      phaseAcc  <= phaseAcc + phaseStep;
      loopErr   <= loopErr + errDiffShift[ARM_W-1:0];
      phaseStep <= stepClamped[PHASE_W-1:0];
    end
  end

endmodule

// File: rtl/costas_track_ctl.sv
module costas_track_ctl
  import costas_track_pkg::*;
#(
  parameter int ERR_W    = 16,
  parameter int LOCK_LEN = 64,
  localparam int CNT_W   = $clog2(LOCK_LEN + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic signed [ERR_W-1:0] loopErr,
  input  logic [ERR_W-1:0]        lockThresh,
  output ctlStrobes_t             ctrl,
  output logic                    locked
);

  logic [ERR_W:0]   errMag;
  logic             errBelow;
  logic [CNT_W-1:0] runCnt;

  assign ctrl.advance = inValid;
  assign errMag   = loopErr[ERR_W-1] ? (ERR_W+1)'(-$signed({loopErr[ERR_W-1], loopErr}))
                                     : {1'b0, loopErr};
  assign errBelow = errMag < {1'b0, lockThresh};

  always_ff @(posedge clk) begin
    if (rst) begin
      runCnt <= '0;
      locked <= 1'b0;
    end else if (ctrl.advance) begin
      if (errBelow) begin
        runCnt <= (runCnt == CNT_W'(LOCK_LEN)) ? runCnt : runCnt + 1'b1;
        locked <= (runCnt >= CNT_W'(LOCK_LEN - 1));
      end else begin
        runCnt <= '0;
        locked <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/costas_track.sv
module costas_track
  import costas_track_pkg::*;
#(
  parameter int PHASE_W    = 16,
  parameter int SAMP_W     = 8,
  parameter int FILT_SHIFT = 4,
  parameter int ERR_SHIFT  = 14,
  parameter int GAIN_SHIFT = 2,
  parameter int LOCK_LEN   = 64,
  localparam int ARM_W     = SAMP_W + SINE_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic signed [SAMP_W-1:0] sampleIn,
  input  logic [PHASE_W-1:0]       nomStep,
  input  logic [PHASE_W-1:0]       minStep,
  input  logic [PHASE_W-1:0]       maxStep,
  input  logic [ARM_W-1:0]         lockThresh,
  output logic signed [ARM_W-1:0]  iArm,
  output logic                     bitOut,
  output logic signed [ARM_W-1:0]  loopErr,
  output logic [PHASE_W-1:0]       phaseStep,
  output logic                     locked
);

  ctlStrobes_t ctrl;

  costas_track_ctl #(.ERR_W(ARM_W), .LOCK_LEN(LOCK_LEN)) u_ctl (
    .clk(clk), .rst(rst), .inValid(inValid), .loopErr(loopErr),
    .lockThresh(lockThresh), .ctrl(ctrl), .locked(locked)
  );

  costas_track_dp #(
    .PHASE_W(PHASE_W), .SAMP_W(SAMP_W), .FILT_SHIFT(FILT_SHIFT),
    .ERR_SHIFT(ERR_SHIFT), .GAIN_SHIFT(GAIN_SHIFT)
  ) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .sampleIn(sampleIn),
    .nomStep(nomStep), .minStep(minStep), .maxStep(maxStep),
    .iArm(iArm), .loopErr(loopErr), .phaseStep(phaseStep)
  );

  assign bitOut = ~iArm[ARM_W-1];

endmodule

// File: rtl/costas_track_chk.sv
module costas_track_chk #(
  parameter int PHASE_W = 16,
  parameter int ARM_W   = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    inValid,
  input logic [PHASE_W-1:0]      nomStep,
  input logic [PHASE_W-1:0]      minStep,
  input logic [PHASE_W-1:0]      maxStep,
  input logic [ARM_W-1:0]        lockThresh,
  input logic signed [ARM_W-1:0] iArm,
  input logic signed [ARM_W-1:0] loopErr,
  input logic [PHASE_W-1:0]      phaseStep,
  input logic                    locked
);

  logic [ARM_W:0] errMagChk;
  assign errMagChk = loopErr[ARM_W-1] ? (ARM_W+1)'(-$signed({loopErr[ARM_W-1], loopErr}))
                                      : {1'b0, loopErr};

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(iArm) && $stable(loopErr) && $stable(phaseStep) && $stable(locked)));

  // R6
  step_in_bounds_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && (minStep <= maxStep)) |=>
      ((phaseStep >= $past(minStep)) && (phaseStep <= $past(maxStep))));

  // R6
  min_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && (minStep > maxStep)) |=> (phaseStep == $past(minStep)));

  // R9
  lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && (errMagChk >= {1'b0, lockThresh})) |=> !locked);

  // R8
  lock_rise_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(inValid));

  // R8
  lock_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && locked && (errMagChk < {1'b0, lockThresh})) |=> locked);

endmodule

bind costas_track costas_track_chk #(.PHASE_W(PHASE_W), .ARM_W(ARM_W)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .nomStep(nomStep), .minStep(minStep),
  .maxStep(maxStep), .lockThresh(lockThresh), .iArm(iArm), .loopErr(loopErr),
  .phaseStep(phaseStep), .locked(locked)
);

// File: tb/costas_track_tb.sv
module costas_track_tb;

  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [7:0] sampleIn = '0;
  logic [15:0] nomStep = 16'h0800;
  logic [15:0] minStep = 16'h0600;
  logic [15:0] maxStep = 16'h0A00;
  logic [15:0] lockThresh = 16'd200;
  logic signed [15:0] iArm;
  logic bitOut;
  logic signed [15:0] loopErr;
  logic [15:0] phaseStep;
  logic locked;

  always #2 clk = ~clk;

  costas_track u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .sampleIn(sampleIn),
    .nomStep(nomStep), .minStep(minStep), .maxStep(maxStep), .lockThresh(lockThresh),
    .iArm(iArm), .bitOut(bitOut), .loopErr(loopErr), .phaseStep(phaseStep), .locked(locked)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    int arm;
    int err;
    int step;
    int lk;
    int bt;
  } expItem_t;

  expItem_t expQ[$];

  // reference state built from the requirement equations
  int mPhase, mStep, mI, mQ, mErr, mCnt, mLock;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sineRef(input int k);
    real r;
    r = 127.0 * $sin(2.0 * PI * real'(k) / 64.0);
    if (r >= 0.0) return int'($floor(r + 0.5));
    return -int'($floor(-r + 0.5));
  endfunction

  task automatic modelReset();
    mPhase = 0; mStep = int'(nomStep); mI = 0; mQ = 0; mErr = 0; mCnt = 0; mLock = 0;
  endtask

  task automatic modelStep(input int x);
    int idx, s, c, nI, nQ, prod, nE, v, mag, below;
    expItem_t it;
    idx = (mPhase >> 10) & 63;
    s = sineRef(idx);
    c = sineRef((idx + 16) & 63);
    nI = mI + ((x * s - mI) >>> 4);
    nQ = mQ + ((x * c - mQ) >>> 4);
    prod = mI * mQ;
    nE = mErr + (((prod >>> 14) - mErr) >>> 4);
    v = int'(nomStep) + (mErr >>> 2);
    if (v > int'(maxStep)) v = int'(maxStep);
    if (v < int'(minStep)) v = int'(minStep);
    mag = (mErr < 0) ? -mErr : mErr;
    below = (mag < int'(lockThresh)) ? 1 : 0;
    mLock = (below != 0 && mCnt >= 63) ? 1 : 0;
    mCnt = (below != 0) ? ((mCnt == 64) ? 64 : mCnt + 1) : 0;
    mPhase = (mPhase + mStep) & 16'hFFFF;
    mStep = v; mI = nI; mQ = nQ; mErr = nE;
    it.arm = nI; it.err = nE; it.step = v; it.lk = mLock; it.bt = (nI >= 0) ? 1 : 0;
    expQ.push_back(it);
  endtask

  // driver: called at a falling edge, leaves the strobe high for one rising edge
  task automatic sendSample(input int x);
    modelStep(x);
    sampleIn = 8'(x);
    inValid = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor
  logic sawValid = 1'b0;
  always @(posedge clk) sawValid <= inValid && !rst;

  initial begin
    forever begin
      @(negedge clk);
      if (sawValid) begin
        expItem_t e;
        if (expQ.size() == 0) begin
          chk("R1 queue", 1, 0);
        end else begin
          e = expQ.pop_front();
          chk("R2 iArm", int'(iArm), e.arm);
          chk("R3 loopErr", int'(loopErr), e.err);
          chk("R4 phaseStep", int'(phaseStep), e.step);
          chk("R8 locked", int'(locked), e.lk);
          chk("R5 bitOut", int'(bitOut), e.bt);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int inAcc;
    int d;
    int x;
    int holdI, holdE, holdS, holdL;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 iArm", int'(iArm), 0);
    chk("R10 loopErr", int'(loopErr), 0);
    chk("R10 locked", int'(locked), 0);
    chk("R10 phaseStep", int'(phaseStep), int'(nomStep));
    rst = 1'b0;
    modelReset();
    @(negedge clk);

    // R8 lock after 64 quiet samples
    for (int n = 1; n <= 63; n++) sendSample(0);
    chk("R8 not yet locked at 63", int'(locked), 0);
    sendSample(0);
    chk("R8 locked at 64", int'(locked), 1);
    for (int n = 0; n < 6; n++) sendSample(0);
    chk("R8 lock held", int'(locked), 1);

    // R9 a sample not below the threshold drops lock
    lockThresh = 16'd0;
    sendSample(0);
    chk("R9 lock dropped", int'(locked), 0);
    lockThresh = 16'd200;

    // R7 idle cycles with changing input leave everything unchanged
    holdI = int'(iArm); holdE = int'(loopErr); holdS = int'(phaseStep); holdL = int'(locked);
    inValid = 1'b0;
    for (int n = 0; n < 6; n++) begin
      sampleIn = 8'(n * 37 - 90);
      @(negedge clk);
    end
    chk("R7 iArm held", int'(iArm), holdI);
    chk("R7 loopErr held", int'(loopErr), holdE);
    chk("R7 phaseStep held", int'(phaseStep), holdS);
    chk("R7 locked held", int'(locked), holdL);

    // R1 R2 R3 R4 modulated carrier slightly above nominal, data flips
    inAcc = 0;
    d = 1;
    for (int n = 0; n < 600; n++) begin
      if (n % 40 == 39) d = -d;
      x = int'($floor(100.0 * real'(d) * $sin(2.0 * PI * real'(inAcc) / 65536.0) + 0.5));
      inAcc = (inAcc + 16'h0840) & 16'hFFFF;
      sendSample(x);
    end
    chk("R5 bit follows arm sign", int'(bitOut), (iArm >= 0) ? 1 : 0);

    // R6 upper bound below nominal
    maxStep = 16'h0700;
    sendSample(50);
    chk("R6 step at or under upper bound", (phaseStep <= 16'h0700) ? 1 : 0, 1);

    // R6 crossed bounds: lower bound wins
    minStep = 16'h0900;
    sendSample(-50);
    chk("R6 lower bound wins", int'(phaseStep), 16'h0900);
    minStep = 16'h0600;
    maxStep = 16'h0A00;
    for (int n = 0; n < 20; n++) sendSample((n % 2 == 0) ? 90 : -90);
    idle(3);

    chk("R1 all expected consumed", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule